// File: doc/BRIEF.md
# Chip-Selected Serial Frame Receiver

This block takes frames from a host controller over three wires: a chip select that is active low, a serial data line and a shift clock. While the chip select is held low, each rising edge of the shift clock moves one data bit into a 112-stage shift register. When the chip select goes high again, the register contents are committed to one of two output words. Which word receives them is decided by a mode flag, which is the last bit of the frame.

A display frame is 112 bits long and fills a 111-bit pattern word. A brightness frame is 16 bits long. Its ten value bits are sent least significant bit first and land in the 10-bit brightness word. The host-side wires are treated as asynchronous. They pass through synchronizers into the system clock domain, and all edge detection is done there.

Top module: `serial_frame_rx`

## Requirements
- R1: A synchronous active-high `rst` clears the shift register, `pattern_o` and `bright_o` to all zeros.
- R2: A bit is shifted only on a detected rising edge of `sclk` while `cs_n` is low. Shift clocks that arrive while `cs_n` is high leave the register unchanged.
- R3: The first bit shifted lands at frame position 1 (register index 0). The last bit shifted lands at position 112 (index 111), which holds the mode flag.
- R4: On release with mode flag 1, frame positions 1 to 111 are copied to `pattern_o[0]` to `pattern_o[110]`.
- R5: On release with mode flag 0, frame positions 97 (LSB) to 106 (MSB) are copied to `bright_o`. A 16-bit frame therefore carries the value LSB first, then five ignored bits, then the flag. Positions 107 to 111 have no effect.
- R6: A brightness load leaves `pattern_o` unchanged.
- R7: A display load leaves `bright_o` unchanged.
- R8: The outputs change only as a result of a `cs_n` release. The new value appears at the third rising edge of `clk` after `cs_n` is seen high, and the outputs are still unchanged after the second edge.
- R9: A release that follows a chip-select assertion with no shift clocks captures the current register contents.
- R10: A shift-clock edge that is detected in the same cycle as the `cs_n` release is not shifted. The capture uses the register as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select from host, active low, asynchronous |
| sclk | input | 1 | Shift clock from host, asynchronous |
| sdata | input | 1 | Serial data from host, asynchronous |
| pattern_o | output | 111 | Latched display pattern; bit 0 is frame position 1 |
| bright_o | output | 10 | Latched brightness value |

## Verification
Shifting and capture can fall in the same system-clock cycle. This happens when the host raises the shift clock at the same instant it releases chip select. The bench provokes it by driving both wires high on the same falling edge of `clk`. Both signals then pass through equal-depth synchronizers and their edges are detected together. The bench withholds a 16th bit that would flip the mode flag to 1. If that bit were wrongly shifted, the pattern word would be reloaded. Since it must be dropped, only the brightness word changes, and it takes the value formed by the earlier 15 bits.

// File: rtl/serial_frame_pkg.sv
package serial_frame_pkg;

    localparam int FRAME_BITS_DEF = 112;
    localparam int BRT_BITS_DEF   = 10;
    localparam int BRT_LSB_DEF    = 96;
    localparam int SYNC_DEPTH_DEF = 2;

    // Lane numbering inside the input synchronizer
    localparam int LANE_SCLK = 0;
    localparam int LANE_CS   = 1;
    localparam int LANE_DATA = 2;
    localparam int LANES     = 3;
    localparam int EDGE_LANES = 2;

    typedef enum logic {
        LOAD_BRIGHT  = 1'b0,
        LOAD_PATTERN = 1'b1
    } load_kind_e;

    typedef struct packed {
        logic shift;
        logic capture;
        logic data;
    } strobe_t;

    function automatic load_kind_e kind_of(input logic flag);
        return flag ? LOAD_PATTERN : LOAD_BRIGHT;
    endfunction

endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
    parameter int STAGES = 2,
    parameter int NLANES = 3,
    parameter int NEDGE  = 2,
    parameter logic [NLANES-1:0] IDLE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLANES-1:0] async_i,
    output logic [NLANES-1:0] level_o,
    output logic [NEDGE-1:0]  rise_o
);

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{IDLE[g]}};
            else     chain <= {chain[STAGES-2:0], async_i[g]};
        end

        assign level_o[g] = chain[STAGES-1];

        if (g < NEDGE) begin : g_edge
            logic prev;
            always_ff @(posedge clk) begin
                if (rst) prev <= IDLE[g];
                else     prev <= chain[STAGES-1];
            end
            assign rise_o[g] = chain[STAGES-1] & ~prev;
        end
    end

endmodule

// File: rtl/frame_shift.sv
module frame_shift #(
    parameter int W = 112
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] sr_o
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)          sr <= '0;
        else if (shift_i) sr <= {bit_i, sr[W-1:1]};
    end

    assign sr_o = sr;

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(sr));

    assert_order_R3: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (sr[W-2:0] == $past(sr[W-1:1])) && (sr[W-1] == $past(bit_i)));

endmodule

// File: rtl/frame_capture.sv
module frame_capture
    import serial_frame_pkg::*;
#(
    parameter int W       = 112,
    parameter int BRT_W   = 10,
    parameter int BRT_LSB = 96,
    localparam int PAT_W  = W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_i,
    input  logic [W-1:0]     frame_i,
    output logic [PAT_W-1:0] pattern_o,
    output logic [BRT_W-1:0] bright_o
);

    load_kind_e kind;
    assign kind = kind_of(frame_i[W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            pattern_o <= '0;
            bright_o  <= '0;
        end else if (capture_i) begin
            if (kind == LOAD_PATTERN) pattern_o <= frame_i[PAT_W-1:0];
            else                      bright_o  <= frame_i[BRT_LSB +: BRT_W];
        end
    end

    assert_keep_pattern_R6: assert property (@(posedge clk) disable iff (rst)
        (capture_i && kind == LOAD_BRIGHT) |=> $stable(pattern_o));

    assert_keep_bright_R7: assert property (@(posedge clk) disable iff (rst)
        (capture_i && kind == LOAD_PATTERN) |=> $stable(bright_o));

    assert_only_on_release_R8: assert property (@(posedge clk) disable iff (rst)
        !capture_i |=> ($stable(pattern_o) && $stable(bright_o)));

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import serial_frame_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_BITS_DEF,
    parameter int BRT_BITS   = BRT_BITS_DEF,
    parameter int BRT_LSB    = BRT_LSB_DEF,
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF,
    localparam int PAT_BITS  = FRAME_BITS - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                sdata,
    output logic [PAT_BITS-1:0] pattern_o,
    output logic [BRT_BITS-1:0] bright_o
);

    logic [LANES-1:0]      lvl;
    logic [EDGE_LANES-1:0] rise;
    logic [LANES-1:0]      raw;
    logic [FRAME_BITS-1:0] frame;
    strobe_t               stb;

    always_comb begin
        raw = '0;
        raw[LANE_SCLK] = sclk;
        raw[LANE_CS]   = cs_n;
        raw[LANE_DATA] = sdata;
    end

    serial_sync #(
        .STAGES (SYNC_DEPTH),
        .NLANES (LANES),
        .NEDGE  (EDGE_LANES),
        .IDLE   (LANES'(1) << LANE_CS)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw),
        .level_o (lvl),
        .rise_o  (rise)
    );

    // A clock edge seen while the synchronized select is already high is dropped
    always_comb begin
        stb.shift   = rise[LANE_SCLK] & ~lvl[LANE_CS];
        stb.capture = rise[LANE_CS];
        stb.data    = lvl[LANE_DATA];
    end

    frame_shift #(.W(FRAME_BITS)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .shift_i (stb.shift),
        .bit_i   (stb.data),
        .sr_o    (frame)
    );

    frame_capture #(
        .W       (FRAME_BITS),
        .BRT_W   (BRT_BITS),
        .BRT_LSB (BRT_LSB)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .capture_i (stb.capture),
        .frame_i   (frame),
        .pattern_o (pattern_o),
        .bright_o  (bright_o)
    );

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        stb.capture |-> !stb.shift);

endmodule

// File: tb/test_serial_frame_rx.sv
module test_serial_frame_rx;

    localparam int FB = 112;
    localparam int PB = FB - 1;
    localparam int BB = 10;
    localparam int NV = 5;

    // bit 0 of each entry is sent first
    localparam logic [FB-1:0] VBITS [NV] = '{
        112'h8123_4567_89AB_CDEF_0F1E_2D3C_4B5A,
        112'h5AA5,
        112'hC000_0000_0000_0000_0000_0000_0001,
        112'h03FF,
        112'h7C00
    };
    localparam int VLEN [NV] = '{112, 16, 112, 16, 16};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic [PB-1:0] pattern;
    logic [BB-1:0] bright;

    logic [FB-1:0] m_sr = '0;
    logic [PB-1:0] e_pat = '0;
    logic [BB-1:0] e_brt = '0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    serial_frame_rx i_serial_frame_rx (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdata     (sdata),
        .pattern_o (pattern),
        .bright_o  (bright)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) sdata = b;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        if (!cs_n) m_sr = {b, m_sr[FB-1:1]};
        repeat (3) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic open_frame();
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Releases select, optionally with a coincident shift-clock rise, and checks timing
    task automatic close_frame(input string req, input bit with_clk);
        logic [PB-1:0] old_pat;
        logic [BB-1:0] old_brt;
        @(negedge clk);
        cs_n = 1'b1;
        if (with_clk) sclk = 1'b1;
        old_pat = pattern;
        old_brt = bright;
        if (m_sr[FB-1]) e_pat = m_sr[PB-1:0];
        else            e_brt = m_sr[96 +: BB];
        repeat (2) @(posedge clk);
        @(negedge clk);
        check({"R8 hold before third edge pattern ", req}, 128'(pattern), 128'(old_pat));
        check({"R8 hold before third edge bright ", req}, 128'(bright), 128'(old_brt));
        @(posedge clk);
        @(negedge clk);
        check({"pattern ", req}, 128'(pattern), 128'(e_pat));
        check({"bright ", req}, 128'(bright), 128'(e_brt));
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [FB-1:0] bits, input int len, input string req);
        open_frame();
        for (int i = 0; i < len; i++) send_bit(bits[i]);
        close_frame(req, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset pattern", 128'(pattern), 128'(0));
        check("R1 reset bright", 128'(bright), 128'(0));

        // Vector table: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            send_frame(VBITS[v], VLEN[v], VBITS[v][VLEN[v]-1] ? "R4 R3 R7 display" : "R5 R6 brightness");
        end

        // R2: clocks with select high are ignored; R9: empty frame re-captures
        send_frame(112'h0155, 16, "R5 setup");
        for (int k = 0; k < 6; k++) send_bit(1'b1);
        open_frame();
        close_frame("R2 R9 idle clocks then empty frame", 1'b0);

        // R10: 16th bit arrives with the release and must not be shifted
        open_frame();
        for (int i = 0; i < 15; i++) send_bit(i < 10 ? ((10'h0AB >> i) & 1'b1) : 1'b0);
        @(negedge clk) sdata = 1'b1;
        repeat (2) @(negedge clk);
        close_frame("R10 coincident shift and release", 1'b1);

        // R1 mid-run: clear after a display frame, then empty frame shows cleared register
        send_frame(VBITS[0], VLEN[0], "R4 before reset");
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_sr = '0;
        e_pat = '0;
        e_brt = '0;
        @(negedge clk);
        check("R1 mid reset pattern", 128'(pattern), 128'(0));
        check("R1 mid reset bright", 128'(bright), 128'(0));
        open_frame();
        close_frame("R1 R9 register cleared", 1'b0);

        report();
    end

endmodule